// File: doc/BRIEF.md
# Interleave Decoder Target Lookup

This block turns a host physical address into the number of the downstream port that owns it, for a memory range that is striped across up to eight ports. Software first programs a control register, which holds an interleave granularity code and an interleave way-count code, and fills two 32-bit target-list registers. It then sets a committed flag. From then on, each lookup strobe yields a registered hit indication and an 8-bit port number one cycle later.

The address is cut into granules of 256 bytes shifted left by the granularity code. The low bits of the granule index pick a slot, and the slot picks a byte out of the packed target list. The programming interface has a write strobe, a 2-bit register select and 32 bits of data. There is no readback. Once the decoder is committed, its programming is frozen. The only write that still takes effect is a control write that drops the committed flag.

Top module: `ileave_decoder`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `res_valid`, `res_hit` and `res_port` are all 0.
- R2: A lookup presented on `lk_valid` at a clock edge gives `res_valid`=1 after that edge and no earlier. `res_valid` is 0 in every cycle that follows an edge where `lk_valid` was low.
- R3: While the committed flag (control bit 8) is clear, every lookup returns `res_hit`=0. Any result with `res_hit`=0 has `res_port`=0.
- R4: With granularity code g (control bits 3:0) and way code w (control bits 7:4, w ≤ 3), the slot is (address >> (8+g)) mod 2^w.
- R5: Slots 0 to 3 read the low target-list register (select 1). Slot k returns bits 8k+7 down to 8k.
- R6: Slots 4 to 7 read the high target-list register (select 2). Slot k returns bits 8(k-4)+7 down to 8(k-4).
- R7: A way code above 3 makes every lookup miss, even when the decoder is committed.
- R8: While committed, writes to the target-list registers, and control writes with bit 8 set, change nothing that a lookup returns.
- R9: While committed, a control write (select 0) with bit 8 clear uncommits the decoder, so that later lookups miss. After that, new programming and a new commit take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 control, 1 low target list, 2 high target list, 3 unused |
| wr_data | input | 32 | Write data |
| lk_valid | input | 1 | Lookup strobe |
| lk_addr | input | ADDR_W | Host physical address to decode |
| res_valid | output | 1 | Result present (one cycle after strobe) |
| res_hit | output | 1 | Target found |
| res_port | output | 8 | Selected downstream port number, 0 on miss |

## Verification
Every target-list byte holds a distinct value, so a wrong slot or a wrong byte lane shows up as a wrong port number. With 256-byte granules and eight ways, the test addresses walk slots 0 to 7, and one of them wraps past eight granules. This separates the low and high registers and shows the modulo step. A second setup with 1 KiB granules and four ways uses addresses whose lower bits would pick a different slot if the shift were wrong. It also uses an address whose granule index is 5, which must fold to slot 1. Single-way, over-range way codes, uncommitted lookups, and writes made while committed then confirm the gating and freeze rules.

// File: rtl/ileave_decoder.sv
module ileave_decoder #(
  parameter int ADDR_W = 48,
  parameter int GRAN_W = 4,
  parameter int WAYS_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [31:0]       wr_data,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              res_valid,
  output logic              res_hit,
  output logic [7:0]        res_port
);
  localparam int BASE_SHIFT = 8;
  localparam int COMMIT_BIT = GRAN_W + WAYS_W;
  localparam int MAX_WAYS   = 3;

  logic              commit_q;
  logic [GRAN_W-1:0] gran_q;
  logic [WAYS_W-1:0] ways_q;
  logic [31:0]       tl_lo_q, tl_hi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      commit_q <= 1'b0;
      gran_q   <= '0;
      ways_q   <= '0;
      tl_lo_q  <= '0;
      tl_hi_q  <= '0;
    end else if (wr_en) begin
      if (!commit_q) begin
        case (wr_sel)
          2'd0: begin
            gran_q   <= wr_data[GRAN_W-1:0];
            ways_q   <= wr_data[GRAN_W +: WAYS_W];
            commit_q <= wr_data[COMMIT_BIT];
          end
          2'd1: tl_lo_q <= wr_data;
          2'd2: tl_hi_q <= wr_data;
          default: ;
        endcase
      end else if (wr_sel == 2'd0 && !wr_data[COMMIT_BIT]) begin
        commit_q <= 1'b0;
      end
    end
  end

  logic [ADDR_W-1:0] granule;
  logic [2:0]        way_mask, slot;
  logic [63:0]       tlist;
  logic              ways_ok;

  assign granule  = lk_addr >> (BASE_SHIFT + int'(gran_q));
  assign ways_ok  = int'(ways_q) <= MAX_WAYS;
  assign way_mask = 3'((4'b1 << ways_q[1:0]) - 4'b1);
  assign slot     = granule[2:0] & way_mask;
  assign tlist    = {tl_hi_q, tl_lo_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_port  <= '0;
    end else begin
      res_valid <= lk_valid;
      res_hit   <= lk_valid && commit_q && ways_ok;
      res_port  <= (lk_valid && commit_q && ways_ok) ? tlist[slot*8 +: 8] : 8'd0;
    end
  end

  // R2
  lookup_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> res_valid);
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !res_valid && !res_hit);
  // R3
  uncommitted_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && !commit_q |=> !res_hit);
  // R3
  miss_port_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_hit |-> res_port == 8'd0);
  // R7
  bad_ways_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && int'(ways_q) > MAX_WAYS |=> !res_hit);
  // R8
  frozen_list_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_q && wr_en && wr_sel != 2'd0 |=> $stable(tl_lo_q) && $stable(tl_hi_q));
endmodule

// File: tb/ileave_decoder_tb.sv
module ileave_decoder_tb;
  localparam int ADDR_W = 48;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [1:0]        wr_sel = '0;
  logic [31:0]       wr_data = '0;
  logic              lk_valid = 1'b0;
  logic [ADDR_W-1:0] lk_addr = '0;
  logic              res_valid, res_hit;
  logic [7:0]        res_port;
  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  ileave_decoder #(.ADDR_W(ADDR_W)) u_dut (.*);

  localparam logic [31:0] LO = 32'hA3A2A1A0;
  localparam logic [31:0] HI = 32'hB7B6B5B4;

  function automatic logic [31:0] ctrl(input int g, input int w, input bit c);
    return {23'd0, c, 4'(w), 4'(g)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic look(input string req, input logic [ADDR_W-1:0] a, input bit hit, input logic [7:0] port);
    @(negedge clk); lk_valid = 1'b1; lk_addr = a;
    @(negedge clk); lk_valid = 1'b0;
    chk({req, " valid"}, 32'(res_valid), 32'd1);
    chk({req, " hit"}, 32'(res_hit), 32'(hit));
    chk({req, " port"}, 32'(res_port), 32'(hit ? port : 8'd0));
    @(negedge clk);
    chk({req, " R2 idle"}, 32'(res_valid), 32'd0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R1 reset", {res_valid, res_hit, res_port}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {res_valid, res_hit, res_port}, 32'd0);
  endtask

  task automatic t_uncommitted;
    wr(2'd1, LO); wr(2'd2, HI); wr(2'd0, ctrl(0, 3, 0));
    look("R3 uncommitted", 48'h100, 0, 0);
  endtask

  task automatic t_eight_way;
    wr(2'd0, ctrl(0, 3, 1));
    look("R5 slot0", 48'h000, 1, 8'hA0);
    look("R5 slot1", 48'h1FF, 1, 8'hA1);
    look("R5 slot3", 48'h300, 1, 8'hA3);
    look("R6 slot4", 48'h400, 1, 8'hB4);
    look("R6 slot7", 48'h7C0, 1, 8'hB7);
    look("R4 wrap", 48'h900, 1, 8'hA1);
  endtask

  task automatic t_gran_four_way;
    wr(2'd0, ctrl(0, 0, 0));
    wr(2'd0, ctrl(2, 2, 1));
    look("R4 gran slot3", 48'hC00, 1, 8'hA3);
    look("R4 fold 5->1", 48'h1400, 1, 8'hA1);
    look("R4 in-granule", 48'h3FF, 1, 8'hA0);
  endtask

  task automatic t_frozen;
    wr(2'd1, 32'h0);
    look("R8 list frozen", 48'h400, 1, 8'hA1);
    wr(2'd0, ctrl(0, 3, 1));
    look("R8 ctrl frozen", 48'h1000, 1, 8'hA0);
  endtask

  task automatic t_uncommit;
    wr(2'd0, ctrl(0, 0, 0));
    look("R9 cleared", 48'h400, 0, 0);
    wr(2'd2, 32'hC7C6C5C4);
    wr(2'd0, ctrl(0, 3, 1));
    look("R9 recommit", 48'h500, 1, 8'hC5);
  endtask

  task automatic t_ways;
    wr(2'd0, ctrl(0, 0, 0));
    wr(2'd0, ctrl(0, 4, 1));
    look("R7 ways4", 48'h100, 0, 0);
    wr(2'd0, ctrl(0, 0, 0));
    wr(2'd0, ctrl(0, 0, 1));
    look("R4 one way", 48'h700, 1, 8'hA0);
  endtask

  initial begin
    #(4 * 100000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_uncommitted();
    t_eight_way();
    t_gran_four_way();
    t_frozen();
    t_uncommit();
    t_ways();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule